// File: doc/BRIEF.md
# Machine-Check Severity Promotion and Error Log

This block takes error reports from several detectors in the same clock cycle and gives each one a severity: corrected, local machine check, global machine check or hardware bus reset. Three configuration enables can raise a severity by one level each. Because the enables form a chain, a promoted error can be promoted again. Each report sets a sticky pending flag for its final severity. A corrected error raises the low-priority corrected-error interrupt.

A sticky log keeps the first error it sees: the final severity, the physical address, the cache hit flag and the tag-or-data flag. Any later report, or any extra report that arrives in the same cycle, sets the overflow bit and leaves the stored error in place. When several reports arrive together, the one with the highest final severity is stored. The error handler clears the status and the pending flags with separate strobes. While machine checks are masked, the local and global requests are held back, but their pending flags stay set until the handler clears them.

Top module: `mc_severity_log`

## Requirements
- R1: Severity codes are 0 corrected, 1 local, 2 global and 3 bus reset. The control field has bit0 to raise corrected to local, bit1 to raise local to global and bit2 to raise global to bus reset. The links are applied in that order, so with all three bits set a corrected error ends at bus reset.
- R2: Promotion stops at the first link that is disabled. With control 3'b010, a corrected error stays corrected.
- R3: Every valid report sets pending bit `pend_o[s]` for its final severity s. The bit positions are 0 corrected interrupt, 1 local, 2 global and 3 bus reset. Pending bits stay set until `clr_sig` is pulsed.
- R4: While `log_valid` is set, a new report does not change the stored severity, address or flags, and it sets `log_ovf`.
- R5: When two or more reports arrive in one cycle, the stored error is the one with the highest final severity. On a tie, the lowest source index wins. `log_ovf` is set in that case.
- R6: A report whose final severity is corrected drives `cmci_irq` high from the next cycle.
- R7: While `mc_mask` is high, `mc_local` and `mc_global` stay low even when their pending bits are set. They go high once the mask drops. `bus_reset` is never masked.
- R8: `clr_stat` clears `log_valid` and `log_ovf`, and `clr_sig` clears the pending bits. A report that arrives in the same cycle as a clear takes effect after the clear.
- R9: The control field changes only through `cfg_we`. The new value applies to reports from the cycle after the write onward. Changing it does not alter an error that is already stored.
- R10: After reset, all pending bits, the log and the control field are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_vld | input | NSRC | One valid bit per error source |
| err_sev | input | 2*NSRC | Raw severity for each source, 2 bits each |
| err_addr | input | AW*NSRC | Physical address for each source |
| err_hit | input | NSRC | Cache hit flag for each source |
| err_tag | input | NSRC | 1 = tag array error, 0 = data array error |
| cfg_we | input | 1 | Control field write strobe |
| cfg_wdata | input | 3 | New promotion enables |
| clr_sig | input | 1 | Clear all pending bits |
| clr_stat | input | 1 | Clear the valid and overflow bits |
| mc_mask | input | 1 | Machine checks masked |
| cmci_irq | output | 1 | Corrected-error interrupt |
| mc_local | output | 1 | Local machine check request |
| mc_global | output | 1 | Global machine check request |
| bus_reset | output | 1 | Hardware bus reset request |
| pend_o | output | 4 | Pending bits for the signaling field |
| log_valid | output | 1 | Log holds an error |
| log_ovf | output | 1 | Error information was lost |
| log_sev | output | 2 | Final severity of the stored error |
| log_addr | output | AW | Address of the stored error |
| log_hit | output | 1 | Hit flag of the stored error |
| log_tag | output | 1 | Tag-or-data flag of the stored error |
| ctl_o | output | 3 | Current control field |

## Verification
The bench drives the promotion chain through full, partial and broken enable patterns. A design that promotes only one step, or that skips a disabled link, would log the wrong severity. It fires three reports in one cycle, including a tie at the top severity. A design that picks the last source or the raw severity would store the wrong address, and one that misses the multi-report case would leave overflow clear. It checks that a second report does not overwrite the stored error. It checks that a masked local request is held pending and is delivered only after the mask drops. It also applies a clear and a new report in the same cycle, and writes the control field in the same cycle as a report, to catch designs that use the wrong order.

// File: rtl/mcsev_pkg.sv
package mcsev_pkg;

    typedef enum logic [1:0] {
        SEV_CORR   = 2'd0,
        SEV_LOCAL  = 2'd1,
        SEV_GLOBAL = 2'd2,
        SEV_RESET  = 2'd3
    } sev_e;

    typedef struct packed {
        logic rst_en;   // bit2: global -> bus reset
        logic glb_en;   // bit1: local -> global
        logic loc_en;   // bit0: corrected -> local
    } promo_cfg_t;

    localparam int NPEND = 4;

    typedef struct packed {
        sev_e sev;
        logic hit;
        logic tag;
    } err_attr_t;

    function automatic sev_e sev_promote(sev_e s, promo_cfg_t c);
        sev_e r;
        r = s;
        if (r == SEV_CORR   && c.loc_en) r = SEV_LOCAL;
        if (r == SEV_LOCAL  && c.glb_en) r = SEV_GLOBAL;
        if (r == SEV_GLOBAL && c.rst_en) r = SEV_RESET;
        return r;
    endfunction

endpackage

// File: rtl/mcsev_promote.sv
module mcsev_promote
    import mcsev_pkg::*;
(
    input  sev_e       sev_in,
    input  promo_cfg_t cfg,
    output sev_e       sev_out
);
    always_comb sev_out = sev_promote(sev_in, cfg);
endmodule

// File: rtl/mcsev_select.sv
module mcsev_select
    import mcsev_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int AW   = 16
) (
    input  logic [NSRC-1:0]    vld,
    input  err_attr_t          attr [NSRC],
    input  logic [NSRC*AW-1:0] addr,
    output logic               any,
    output logic               multi,
    output err_attr_t          win_attr,
    output logic [AW-1:0]      win_addr,
    output logic [NPEND-1:0]   set_pend
);
    localparam int CW = $clog2(NSRC + 1);

    logic [CW-1:0] cnt;

    always_comb begin
        any      = 1'b0;
        cnt      = '0;
        win_attr = '0;
        win_addr = '0;
        set_pend = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (vld[i]) begin
                cnt = cnt + CW'(1);
                set_pend[attr[i].sev] = 1'b1;
                if (!any || attr[i].sev > win_attr.sev) begin
                    win_attr = attr[i];
                    win_addr = addr[i*AW +: AW];
                end
                any = 1'b1;
            end
        end
        multi = (cnt > CW'(1));
    end
endmodule

// File: rtl/mcsev_log.sv
module mcsev_log
    import mcsev_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any,
    input  logic             multi,
    input  err_attr_t        win_attr,
    input  logic [AW-1:0]    win_addr,
    input  logic [NPEND-1:0] set_pend,
    input  logic             clr_sig,
    input  logic             clr_stat,
    output logic [NPEND-1:0] pend_q,
    output logic             valid_q,
    output logic             ovf_q,
    output err_attr_t        attr_q,
    output logic [AW-1:0]    addr_q
);
    logic base_valid;
    logic base_ovf;

    always_comb begin
        base_valid = valid_q & ~clr_stat;
        base_ovf   = ovf_q & ~clr_stat;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            valid_q <= 1'b0;
            ovf_q   <= 1'b0;
            attr_q  <= '0;
            addr_q  <= '0;
        end else begin
            pend_q <= (clr_sig ? '0 : pend_q) | set_pend;
            if (any && !base_valid) begin
                valid_q <= 1'b1;
                ovf_q   <= multi;
                attr_q  <= win_attr;
                addr_q  <= win_addr;
            end else begin
                valid_q <= base_valid;
                ovf_q   <= base_ovf | (any & base_valid);
            end
        end
    end

    // R4
    log_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (valid_q && !clr_stat) |=> (valid_q && $stable(addr_q) && $stable(attr_q)));

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> valid_q);

    // R3
    pend_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_sig |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R8
    stat_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_stat && !any) |=> (!valid_q && !ovf_q));
endmodule

// File: rtl/mc_severity_log.sv
module mc_severity_log
    import mcsev_pkg::*;
#(
    parameter int NSRC = 3,
    parameter int AW   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC-1:0]    err_vld,
    input  logic [2*NSRC-1:0]  err_sev,
    input  logic [NSRC*AW-1:0] err_addr,
    input  logic [NSRC-1:0]    err_hit,
    input  logic [NSRC-1:0]    err_tag,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_wdata,
    input  logic               clr_sig,
    input  logic               clr_stat,
    input  logic               mc_mask,
    output logic               cmci_irq,
    output logic               mc_local,
    output logic               mc_global,
    output logic               bus_reset,
    output logic [NPEND-1:0]   pend_o,
    output logic               log_valid,
    output logic               log_ovf,
    output logic [1:0]         log_sev,
    output logic [AW-1:0]      log_addr,
    output logic               log_hit,
    output logic               log_tag,
    output logic [2:0]         ctl_o
);
    promo_cfg_t       ctl_q;
    sev_e             raw_sev [NSRC];
    sev_e             fin_sev [NSRC];
    err_attr_t        attr    [NSRC];
    logic             any, multi;
    err_attr_t        win_attr;
    logic [AW-1:0]    win_addr;
    logic [NPEND-1:0] set_pend;
    logic [NPEND-1:0] pend_q;
    err_attr_t        attr_q;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (cfg_we) ctl_q <= promo_cfg_t'(cfg_wdata);
    end

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        assign raw_sev[i] = sev_e'(err_sev[2*i +: 2]);

        mcsev_promote u_prom (
            .sev_in  (raw_sev[i]),
            .cfg     (ctl_q),
            .sev_out (fin_sev[i])
        );

        assign attr[i] = '{sev: fin_sev[i], hit: err_hit[i], tag: err_tag[i]};

        // R1
        promo_up_chk: assert property (@(posedge clk) disable iff (rst)
            err_vld[i] |-> (fin_sev[i] >= raw_sev[i]));

        // R5
        win_max_chk: assert property (@(posedge clk) disable iff (rst)
            err_vld[i] |-> (win_attr.sev >= fin_sev[i]));
    end

    mcsev_select #(.NSRC(NSRC), .AW(AW)) u_sel (
        .vld      (err_vld),
        .attr     (attr),
        .addr     (err_addr),
        .any      (any),
        .multi    (multi),
        .win_attr (win_attr),
        .win_addr (win_addr),
        .set_pend (set_pend)
    );

    mcsev_log #(.AW(AW)) u_log (
        .clk      (clk),
        .rst      (rst),
        .any      (any),
        .multi    (multi),
        .win_attr (win_attr),
        .win_addr (win_addr),
        .set_pend (set_pend),
        .clr_sig  (clr_sig),
        .clr_stat (clr_stat),
        .pend_q   (pend_q),
        .valid_q  (log_valid),
        .ovf_q    (log_ovf),
        .attr_q   (attr_q),
        .addr_q   (log_addr)
    );

    always_comb begin
        pend_o    = pend_q;
        cmci_irq  = pend_q[SEV_CORR];
        mc_local  = pend_q[SEV_LOCAL] & ~mc_mask;
        mc_global = pend_q[SEV_GLOBAL] & ~mc_mask;
        bus_reset = pend_q[SEV_RESET];
        log_sev   = attr_q.sev;
        log_hit   = attr_q.hit;
        log_tag   = attr_q.tag;
        ctl_o     = ctl_q;
    end

    // R7
    mask_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mc_mask && pend_q[SEV_LOCAL] && !clr_sig) |=> pend_q[SEV_LOCAL]);
endmodule

// File: tb/sim_mc_severity_log.sv
`timescale 1ns/1ps
module sim_mc_severity_log;
    localparam int NSRC = 3;
    localparam int AW   = 16;

    logic               clk = 1'b0;
    logic               rst;
    logic [NSRC-1:0]    err_vld;
    logic [2*NSRC-1:0]  err_sev;
    logic [NSRC*AW-1:0] err_addr;
    logic [NSRC-1:0]    err_hit;
    logic [NSRC-1:0]    err_tag;
    logic               cfg_we;
    logic [2:0]         cfg_wdata;
    logic               clr_sig, clr_stat, mc_mask;
    logic               cmci_irq, mc_local, mc_global, bus_reset;
    logic [3:0]         pend_o;
    logic               log_valid, log_ovf, log_hit, log_tag;
    logic [1:0]         log_sev;
    logic [AW-1:0]      log_addr;
    logic [2:0]         ctl_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    mc_severity_log #(.NSRC(NSRC), .AW(AW)) u0 (
        .clk(clk), .rst(rst), .err_vld(err_vld), .err_sev(err_sev),
        .err_addr(err_addr), .err_hit(err_hit), .err_tag(err_tag),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .clr_sig(clr_sig),
        .clr_stat(clr_stat), .mc_mask(mc_mask), .cmci_irq(cmci_irq),
        .mc_local(mc_local), .mc_global(mc_global), .bus_reset(bus_reset),
        .pend_o(pend_o), .log_valid(log_valid), .log_ovf(log_ovf),
        .log_sev(log_sev), .log_addr(log_addr), .log_hit(log_hit),
        .log_tag(log_tag), .ctl_o(ctl_o)
    );

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic put(int i, logic [1:0] sev, logic [AW-1:0] a, logic h, logic t);
        err_vld[i]         = 1'b1;
        err_sev[2*i +: 2]  = sev;
        err_addr[i*AW +: AW] = a;
        err_hit[i]         = h;
        err_tag[i]         = t;
    endtask

    task automatic idle();
        err_vld = '0; err_sev = '0; err_addr = '0; err_hit = '0; err_tag = '0;
        cfg_we = 0; clr_sig = 0; clr_stat = 0;
    endtask

    task automatic fire();
        tick();
        idle();
    endtask

    task automatic set_cfg(logic [2:0] v);
        cfg_we = 1; cfg_wdata = v;
        fire();
    endtask

    task automatic clear_all();
        clr_sig = 1; clr_stat = 1;
        fire();
    endtask

    task automatic t_reset();
        chk("R10", "pend", pend_o, 0);
        chk("R10", "valid", log_valid, 0);
        chk("R10", "ovf", log_ovf, 0);
        chk("R10", "ctl", ctl_o, 0);
    endtask

    task automatic t_first_and_ovf();
        put(0, 2'd0, 16'h1234, 1, 0);
        fire();
        chk("R6", "cmci", cmci_irq, 1);
        chk("R3", "pend", pend_o, 4'b0001);
        chk("R4", "valid", log_valid, 1);
        chk("R4", "addr", log_addr, 16'h1234);
        chk("R4", "ovf clear", log_ovf, 0);
        put(2, 2'd2, 16'hBEEF, 0, 1);
        fire();
        chk("R4", "ovf set", log_ovf, 1);
        chk("R4", "addr kept", log_addr, 16'h1234);
        chk("R4", "sev kept", log_sev, 0);
        chk("R4", "hit kept", log_hit, 1);
        chk("R3", "pend both", pend_o, 4'b0101);
        tick();
        chk("R3", "pend sticky", pend_o, 4'b0101);
        clear_all();
        chk("R8", "valid clr", log_valid, 0);
        chk("R8", "ovf clr", log_ovf, 0);
        chk("R8", "pend clr", pend_o, 0);
    endtask

    task automatic t_chain();
        set_cfg(3'b111);
        put(1, 2'd0, 16'h0A0A, 0, 1);
        fire();
        chk("R1", "full chain sev", log_sev, 3);
        chk("R1", "full chain pend", pend_o, 4'b1000);
        chk("R1", "bus_reset", bus_reset, 1);
        chk("R1", "tag", log_tag, 1);
        clear_all();
        set_cfg(3'b011);
        put(0, 2'd0, 16'h0B0B, 0, 0);
        fire();
        chk("R1", "two links sev", log_sev, 2);
        chk("R1", "global out", mc_global, 1);
        clear_all();
        set_cfg(3'b010);
        put(0, 2'd0, 16'h0C0C, 0, 0);
        fire();
        chk("R2", "broken chain sev", log_sev, 0);
        chk("R2", "broken chain cmci", cmci_irq, 1);
        chk("R2", "broken chain pend", pend_o, 4'b0001);
        clear_all();
        set_cfg(3'b000);
    endtask

    task automatic t_multi();
        put(0, 2'd1, 16'hAAAA, 0, 0);
        put(1, 2'd2, 16'hBBBB, 1, 0);
        put(2, 2'd2, 16'hCCCC, 0, 1);
        fire();
        chk("R5", "winner addr", log_addr, 16'hBBBB);
        chk("R5", "winner sev", log_sev, 2);
        chk("R5", "winner hit", log_hit, 1);
        chk("R5", "ovf", log_ovf, 1);
        chk("R5", "pend", pend_o, 4'b0110);
        clear_all();
    endtask

    task automatic t_mask();
        mc_mask = 1;
        put(0, 2'd1, 16'h5555, 0, 0);
        fire();
        chk("R7", "local masked", mc_local, 0);
        chk("R7", "local pending", pend_o[1], 1);
        put(1, 2'd3, 16'h6666, 0, 0);
        fire();
        chk("R7", "reset unmasked", bus_reset, 1);
        mc_mask = 0;
        tick();
        chk("R7", "local delivered", mc_local, 1);
        clear_all();
    endtask

    task automatic t_clear_race();
        put(0, 2'd1, 16'h1111, 0, 0);
        fire();
        put(2, 2'd2, 16'h2222, 1, 1);
        clr_sig = 1; clr_stat = 1;
        fire();
        chk("R8", "new after clear valid", log_valid, 1);
        chk("R8", "new after clear addr", log_addr, 16'h2222);
        chk("R8", "new after clear ovf", log_ovf, 0);
        chk("R8", "new after clear pend", pend_o, 4'b0100);
        clear_all();
    endtask

    task automatic t_cfg_timing();
        put(0, 2'd1, 16'h7777, 0, 0);
        cfg_we = 1; cfg_wdata = 3'b111;
        fire();
        chk("R9", "old cfg used", log_sev, 1);
        chk("R9", "ctl updated", ctl_o, 3'b111);
        set_cfg(3'b000);
        chk("R9", "log unaffected", log_sev, 1);
        chk("R9", "ctl back", ctl_o, 0);
        clear_all();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        cfg_wdata = 0; mc_mask = 0; rst = 1;
        repeat (3) tick();
        rst = 0;
        tick();
        t_reset();
        t_first_and_ovf();
        t_chain();
        t_multi();
        t_mask();
        t_clear_race();
        t_cfg_timing();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule